// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block carries out the 32-bit arithmetic and logical data-processing operations of a processor core and computes the next N, Z, C and V condition flags. It receives the first operand, the second operand as already produced by the barrel shifter, the carry bit that the shifter produced, the current flags, a 4-bit operation code and a set-flags bit. It returns the result, a write strobe for the destination register and the flags the core should hold afterwards.

Sixteen operations are decoded: plain and inverted move, add, add with carry, subtract, reverse subtract and their carry-using forms, AND, OR, XOR, bit clear, and four compare-only operations that update the flags but never write a register. Arithmetic operations take C and V from the adder. Logical operations take C from the shifter and leave V as it was. One operation is accepted per cycle when `op_valid` is high, and all outputs are registered, so each result appears on the cycle after it was issued.

Top module: `dp_alu`

## Requirements
- R1: The opcode selects the operation: 0 AND, 1 XOR, 2 A−B, 3 B−A, 4 A+B, 5 A+B+C, 6 A−B−1+C, 7 B−A−1+C, 8 test (A AND B), 9 test-equal (A XOR B), 10 compare (A−B), 11 compare-negated (A+B), 12 OR, 13 move B, 14 bit clear, 15 move NOT B.
- R2: Logical opcodes produce AND, XOR, OR, B, NOT B and A AND NOT B (0x11111111 with mask 0x01100101 gives 0x10011010).
- R3: Arithmetic opcodes 2, 3 and 4 produce the 32-bit wrapped difference, reversed difference and sum.
- R4: Opcodes 5, 6 and 7 add the incoming C flag (`flags_in[1]`) as carry-in, so an add that sets flags followed by an add-with-carry forms a 64-bit sum.
- R5: Opcodes 8 to 11 never assert `rd_write` and always update the flags whatever `set_flags` holds; every other opcode asserts `rd_write`.
- R6: Flags are packed N, Z, C, V in bits 3, 2, 1, 0. When flags are updated, N is result bit 31 and Z is 1 exactly when the 32-bit result is zero.
- R7: A non-compare operation with `set_flags` low passes `flags_in` to `flags_out` unchanged.
- R8: For arithmetic opcodes C is the adder carry-out (1 means no borrow on subtraction) and V flags signed overflow.
- R9: For logical opcodes (0, 1, 8, 9, 12 to 15) C is taken from `shift_carry` and V keeps its incoming value.
- R10: Outputs appear one clock after `op_valid` is sampled high with `res_valid` set; in a cycle after `op_valid` was low, `res_valid` and `rd_write` are 0. Reset clears every output to zero.

Ports table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request flag update |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| res_valid | output | 1 | Registered outputs hold a new result |
| result | output | 32 | Operation result |
| rd_write | output | 1 | Destination register write strobe |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The only state is the output register, so a fault in decoding, carry selection or flag policy shows at the ports on the very next cycle after the operation is issued, as a wrong result word, a stray or missing write strobe, or one wrong flag bit. Directed operations are chosen so that each flag source is distinguishable: shifter carry differs from adder carry, incoming V differs from the overflow a logical operation could imply, and incoming C differs between carry-using operations. A chained 64-bit add feeds the produced flags back as the next operation's input to show the carry path end to end.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_XOR = 4'h1,
        OP_SUB = 4'h2,
        OP_RSB = 4'h3,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_RSC = 4'h7,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic op_is_compare(alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_SUB) || (op == OP_RSB) || (op == OP_ADD) || (op == OP_ADC) ||
               (op == OP_SBC) || (op == OP_RSC) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

endpackage

// File: rtl/dp_adder.sv
module dp_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    input  logic         add_cin,
    output logic [W-1:0] add_sum,
    output logic         add_cout,
    output logic         add_ovf
);
    localparam int MSB = W - 1;

    logic [W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
        add_sum  = wide_sum[MSB:0];
        add_cout = wide_sum[W];
        add_ovf  = (add_x[MSB] == add_y[MSB]) && (wide_sum[MSB] != add_x[MSB]);
    end
endmodule

// File: rtl/dp_arith.sv
module dp_arith
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] x_sel;
    logic [W-1:0] y_sel;
    logic         cin_sel;

    always_comb begin
        x_sel   = a;
        y_sel   = b;
        cin_sel = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin y_sel = ~b; cin_sel = 1'b1; end
            OP_RSB:         begin x_sel = b; y_sel = ~a; cin_sel = 1'b1; end
            OP_ADC:         begin cin_sel = c_in; end
            OP_SBC:         begin y_sel = ~b; cin_sel = c_in; end
            OP_RSC:         begin x_sel = b; y_sel = ~a; cin_sel = c_in; end
            default:        begin x_sel = a; y_sel = b; cin_sel = 1'b0; end
        endcase
    end

    dp_adder #(.W(W)) u_adder (
        .add_x   (x_sel),
        .add_y   (y_sel),
        .add_cin (cin_sel),
        .add_sum (sum),
        .add_cout(carry),
        .add_ovf (ovf)
    );
endmodule

// File: rtl/dp_logic.sv
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lres
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: lres = a & b;
            OP_XOR, OP_TEQ: lres = a ^ b;
            OP_ORR:         lres = a | b;
            OP_MOV:         lres = b;
            OP_BIC:         lres = a & ~b;
            OP_MVN:         lres = ~b;
            default:        lres = '0;
        endcase
    end
endmodule

// File: rtl/dp_flags.sv
module dp_flags
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic         set_flags,
    input  logic [W-1:0] res,
    input  logic         arith_c,
    input  logic         arith_v,
    input  logic         shift_c,
    input  alu_flags_t   cur,
    output alu_flags_t   nxt,
    output logic         wr
);
    localparam int MSB = W - 1;

    logic upd;
    logic arith;

    always_comb begin
        arith = op_is_arith(op);
        upd   = set_flags || op_is_compare(op);
        wr    = !op_is_compare(op);
        nxt   = cur;
        if (upd) begin
            nxt.n = res[MSB];
            nxt.z = (res == '0);
            nxt.c = arith ? arith_c : shift_c;
            nxt.v = arith ? arith_v : cur.v;
        end
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   opcode,
    input  logic         set_flags,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         shift_carry,
    input  logic [3:0]   flags_in,
    output logic         res_valid,
    output logic [W-1:0] result,
    output logic         rd_write,
    output logic [3:0]   flags_out
);
    alu_op_e      op;
    alu_flags_t   cur_flags;
    alu_flags_t   next_flags;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic [W-1:0] sel_res;
    logic         a_carry;
    logic         a_ovf;
    logic         wr_cmb;

    assign op        = alu_op_e'(opcode);
    assign cur_flags = alu_flags_t'(flags_in);

    dp_arith #(.W(W)) u_arith (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .c_in (cur_flags.c),
        .sum  (arith_res),
        .carry(a_carry),
        .ovf  (a_ovf)
    );

    dp_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .lres(logic_res)
    );

    assign sel_res = op_is_arith(op) ? arith_res : logic_res;

    dp_flags #(.W(W)) u_flags (
        .op       (op),
        .set_flags(set_flags),
        .res      (sel_res),
        .arith_c  (a_carry),
        .arith_v  (a_ovf),
        .shift_c  (shift_carry),
        .cur      (cur_flags),
        .nxt      (next_flags),
        .wr       (wr_cmb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            rd_write  <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            res_valid <= op_valid;
            rd_write  <= op_valid && wr_cmb;
            if (op_valid) begin
                result    <= sel_res;
                flags_out <= next_flags;
            end
        end
    end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   opcode,
    input logic         set_flags,
    input logic         shift_carry,
    input logic [3:0]   flags_in,
    input logic         res_valid,
    input logic [W-1:0] result,
    input logic         rd_write,
    input logic [3:0]   flags_out
);
    logic is_cmp;
    logic is_log;

    assign is_cmp = (opcode[3:2] == 2'b10);
    assign is_log = (opcode == 4'h0) || (opcode == 4'h1) || (opcode == 4'h8) ||
                    (opcode == 4'h9) || (opcode[3:2] == 2'b11);

    // R5
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && is_cmp |=> res_valid && !rd_write);

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !set_flags && !is_cmp |=> flags_out == $past(flags_in));

    // R6
    nz_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (set_flags || is_cmp) |=>
            flags_out[3] == result[W-1] && flags_out[2] == (result == '0));

    // R9
    logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (set_flags || is_cmp) && is_log |=>
            flags_out[1] == $past(shift_carry) && flags_out[0] == $past(flags_in[0]));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && !rd_write);
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .set_flags  (set_flags),
    .shift_carry(shift_carry),
    .flags_in   (flags_in),
    .res_valid  (res_valid),
    .result     (result),
    .rd_write   (rd_write),
    .flags_out  (flags_out)
);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        shift_carry = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        res_valid;
    logic [31:0] result;
    logic        rd_write;
    logic [3:0]  flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dp_alu u_dp_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_carry(shift_carry), .flags_in(flags_in), .res_valid(res_valid),
        .result(result), .rd_write(rd_write), .flags_out(flags_out)
    );

    task automatic check(string req, logic [31:0] er, logic ew, logic [3:0] ef);
        checks++;
        if (res_valid !== 1'b1 || result !== er || rd_write !== ew || flags_out !== ef) begin
            failures++;
            $display("FAIL %s: got v=%b res=%h wr=%b fl=%b, want v=1 res=%h wr=%b fl=%b",
                     req, res_valid, result, rd_write, flags_out, er, ew, ef);
        end
    endtask

    // issue on a falling edge, sample on the next falling edge (after one posedge)
    task automatic issue(logic [3:0] op, logic sf, logic [31:0] a, logic [31:0] b,
                         logic sc, logic [3:0] fl);
        @(negedge clk);
        op_valid = 1'b1; opcode = op; set_flags = sf;
        opnd_a = a; opnd_b = b; shift_carry = sc; flags_in = fl;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        checks++;
        if (res_valid !== 1'b0 || result !== '0 || rd_write !== 1'b0 || flags_out !== '0) begin
            failures++;
            $display("FAIL R10 reset: got v=%b res=%h wr=%b fl=%b, want all zero",
                     res_valid, result, rd_write, flags_out);
        end
    endtask

    task automatic t_logical();
        issue(4'hE, 1'b1, 32'h11111111, 32'h01100101, 1'b0, 4'b0001);
        check("R2 bic/R9 keep V", 32'h10011010, 1'b1, 4'b0001);
        issue(4'hD, 1'b1, 32'h0, 32'h0, 1'b1, 4'b1001);
        check("R6 mov zero/R9 C from shifter", 32'h0, 1'b1, 4'b0111);
        issue(4'hF, 1'b0, 32'h0, 32'h0000FFFF, 1'b1, 4'b0101);
        check("R2 mvn/R7 hold", 32'hFFFF0000, 1'b1, 4'b0101);
        issue(4'h0, 1'b0, 32'hF0F0F0F0, 32'h0FF00FF0, 1'b0, 4'b0000);
        check("R2 and", 32'h00F000F0, 1'b1, 4'b0000);
        issue(4'h1, 1'b1, 32'hFFFF0000, 32'h0F0F0F0F, 1'b0, 4'b0000);
        check("R2 xor/R6 N", 32'hF0F00F0F, 1'b1, 4'b1000);
        issue(4'hC, 1'b0, 32'h12000000, 32'h00000034, 1'b0, 4'b0011);
        check("R1 orr", 32'h12000034, 1'b1, 4'b0011);
    endtask

    task automatic t_arith();
        issue(4'h4, 1'b1, 32'h7FFFFFFF, 32'h1, 1'b0, 4'b0000);
        check("R8 add overflow", 32'h80000000, 1'b1, 4'b1001);
        issue(4'h2, 1'b1, 32'd5, 32'd5, 1'b0, 4'b0000);
        check("R3 sub zero/R8 no borrow", 32'h0, 1'b1, 4'b0110);
        issue(4'h2, 1'b1, 32'd3, 32'd5, 1'b1, 4'b0000);
        check("R8 sub borrow", 32'hFFFFFFFE, 1'b1, 4'b1000);
        issue(4'h2, 1'b1, 32'h80000000, 32'h1, 1'b0, 4'b0000);
        check("R8 sub overflow", 32'h7FFFFFFF, 1'b1, 4'b0011);
        issue(4'h3, 1'b1, 32'd1, 32'd10, 1'b0, 4'b0000);
        check("R3 rsb", 32'd9, 1'b1, 4'b0010);
    endtask

    task automatic t_carry_ops();
        issue(4'h5, 1'b0, 32'd1, 32'd2, 1'b0, 4'b0010);
        check("R4 adc C=1", 32'd4, 1'b1, 4'b0010);
        issue(4'h6, 1'b1, 32'd10, 32'd3, 1'b0, 4'b0000);
        check("R4 sbc C=0", 32'd6, 1'b1, 4'b0010);
        issue(4'h7, 1'b1, 32'd3, 32'd10, 1'b0, 4'b0010);
        check("R4 rsc C=1", 32'd7, 1'b1, 4'b0010);
    endtask

    task automatic t_compare();
        issue(4'hA, 1'b0, 32'd5, 32'd5, 1'b0, 4'b0000);
        check("R5 cmp", 32'h0, 1'b0, 4'b0110);
        issue(4'hB, 1'b0, 32'hFFFFFFFF, 32'h1, 1'b0, 4'b0000);
        check("R5 cmn", 32'h0, 1'b0, 4'b0110);
        issue(4'h8, 1'b0, 32'h000000F0, 32'h0000000F, 1'b1, 4'b0001);
        check("R5 tst/R9", 32'h0, 1'b0, 4'b0111);
        issue(4'h9, 1'b0, 32'h80000000, 32'h0, 1'b0, 4'b0000);
        check("R5 teq", 32'h80000000, 1'b0, 4'b1000);
    endtask

    task automatic t_chain64();
        logic [3:0] lo_flags;
        issue(4'h4, 1'b1, 32'hFFFFFFFF, 32'h1, 1'b0, 4'b0000);
        check("R4 low word", 32'h0, 1'b1, 4'b0110);
        lo_flags = flags_out;
        issue(4'h5, 1'b1, 32'h1, 32'h2, 1'b0, lo_flags);
        check("R4 high word", 32'd4, 1'b1, 4'b0000);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || rd_write !== 1'b0) begin
            failures++;
            $display("FAIL R10 idle: got v=%b wr=%b, want v=0 wr=0", res_valid, rd_write);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_logical();
        t_arith();
        t_carry_ops();
        t_compare();
        t_chain64();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule